// File: doc/BRIEF.md
# Shared-Bitline Dual-Port Access Arbiter

This block sits in front of a one-read/one-write memory bank whose columns are laid out so that every vertical bitline is shared by a neighbouring pair of columns. One column of the pair uses the line as its read line and the other uses it as its write line. Each cycle the block is offered at most one write request and one read request, each with a row number and a word index. With bit interleaving of distance `DIST`, word `w` occupies columns `w`, `w+DIST`, `w+2*DIST` and so on. The block decides whether the read can be sent to the array while a write is in progress.

A write is accepted only when the write port is free. It then drives the array for `WR_LAT` consecutive cycles, and its row, word and data are held stable for that time. A read is issued in the cycle it is offered unless it collides with the write that is active or is being accepted in that cycle. Three collisions are checked. A **row** collision is the same row. A **column** collision is the same word index in another row. A **line** collision is the partner word that shares a bitline with the written word. Writes always win. A colliding read is held off with `rd_ready` low and is re-examined every cycle. Data from an issued read comes back on `rd_dout` with `rd_dval` exactly `RD_LAT` cycles later. Three saturating counters record how many cycles a read waited, and each stalled cycle is charged to one cause only.

The write port is controlled by a two-state machine:
- `WR_IDLE` accepts a write whenever `wr_valid` is high (transition ACCEPT to `WR_BUSY`).
- `WR_BUSY` counts down the latency. On its last cycle it raises `arr_wr_last` and takes transition RETIRE back to `WR_IDLE`, where at least one cycle passes before the next write can start.

Top module: `sbl_port_arbiter`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `wr_ready` is 1, `arr_wr_en` and `rd_dval` are 0, and all three counters read 0.
- R2: A write offered while `wr_ready` is 1 is accepted at that edge. For the next `WR_LAT` cycles `arr_wr_en` is 1, with the accepted row, word and data held on `arr_wr_*`. `arr_wr_last` is 1 only in the final cycle. `wr_ready` is 0 throughout.
- R3: A read that collides with no write has `rd_ready` 1 in the cycle it is offered, even while a write is active. Its array word appears on `rd_dout` with `rd_dval` 1 exactly `RD_LAT` clock edges after the issuing edge.
- R4: A read in the same row as the active or incoming write is stalled (`rd_ready` 0).
- R5: A read in a different row that has the same word index as the active or incoming write is stalled.
- R6: A read of the partner word of the written word is stalled. With `PAIR_UP`=1, the partner of word `w` is `w` with bit 0 inverted. With `PAIR_UP`=0, odd `w` pairs with `w+1` and even `w` pairs with `w-1`, both modulo `DIST`. `DIST` must be even.
- R7: A read of exactly the row and word being written stalls until the write retires. It then returns the newly written data.
- R8: When a write and a colliding read arrive in the same idle cycle, the write is accepted and the read is stalled.
- R9: Each cycle with `rd_valid` 1 and `rd_ready` 0 adds one to exactly one counter, chosen in this order: row (`cnt_row`), then column (`cnt_col`), then line (`cnt_line`). Counters saturate at 65535 and do not change in cycles without a stalled read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write port free; write accepted when both are high |
| wr_row | input | $clog2(ROWS) | Write row |
| wr_word | input | $clog2(DIST) | Write word index |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read may issue this cycle |
| rd_row | input | $clog2(ROWS) | Read row |
| rd_word | input | $clog2(DIST) | Read word index |
| rd_dval | output | 1 | Read data valid |
| rd_dout | output | DATA_W | Read data |
| arr_wr_en | output | 1 | Array write active |
| arr_wr_last | output | 1 | Final cycle of array write; array commits at this edge |
| arr_wr_row | output | $clog2(ROWS) | Array write row |
| arr_wr_word | output | $clog2(DIST) | Array write word |
| arr_wr_data | output | DATA_W | Array write data |
| arr_rd_en | output | 1 | Array read issued |
| arr_rd_row | output | $clog2(ROWS) | Array read row |
| arr_rd_word | output | $clog2(DIST) | Array read word |
| arr_rd_data | input | DATA_W | Array read data, same cycle as arr_rd_en |
| cnt_row | output | 16 | Stall cycles charged to the row cause |
| cnt_col | output | 16 | Stall cycles charged to the column cause |
| cnt_line | output | 16 | Stall cycles charged to the shared-line cause |

## Verification
The arbitration is tried in several ways, each against a behavioural model that is checked every cycle:
- Isolated writes and reads separate the write timing from the read latency.
- Non-colliding reads during a write show that parallel issue is really allowed.
- Directed row, column and partner-word pairs, with both pairing directions of the partner rule, tell the three causes apart through the counter they increment.
- A same-address pair checks that the stalled read returns the new data.
- A same-row, same-word pair checks that only the lowest cause is charged.
- Simultaneous arrival checks the write priority.
- A random mixed stream exercises back-to-back writes.
- A long run of continuous collisions drives the row counter into saturation.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    typedef enum logic [0:0] {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_e;

    typedef enum logic [1:0] {
        CF_NONE = 2'd0,
        CF_ROW  = 2'd1,
        CF_COL  = 2'd2,
        CF_LINE = 2'd3
    } cf_cause_e;

    localparam int unsigned N_CAUSES = 3;

endpackage

// File: rtl/sbl_write_fsm.sv
module sbl_write_fsm #(
    parameter int unsigned ROW_W  = 4,
    parameter int unsigned WORD_W = 2,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WR_LAT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [WORD_W-1:0] req_word,
    input  logic [DATA_W-1:0] req_data,
    output logic              req_ready,
    output logic              act_en,
    output logic              act_last,
    output logic [ROW_W-1:0]  act_row,
    output logic [WORD_W-1:0] act_word,
    output logic [DATA_W-1:0] act_data
);
    import sbl_pkg::*;

    localparam int unsigned LC_W = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;
    localparam logic [LC_W-1:0] LC_LOAD = LC_W'(WR_LAT - 1);

    wr_state_e       state_q, state_d;
    logic [LC_W-1:0] lat_q;
    logic            accept;

    assign accept = (state_q == WR_IDLE) && req_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // transitions: ACCEPT (idle -> busy), RETIRE (busy -> idle)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (req_valid)      state_d = WR_BUSY;
            WR_BUSY: if (lat_q == '0)    state_d = WR_IDLE;
            default:                     state_d = WR_IDLE;
        endcase
    end

    // latency counter and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q    <= '0;
            act_row  <= '0;
            act_word <= '0;
            act_data <= '0;
        end else if (accept) begin
            lat_q    <= LC_LOAD;
            act_row  <= req_row;
            act_word <= req_word;
            act_data <= req_data;
        end else if (state_q == WR_BUSY && lat_q != '0) begin
            lat_q <= lat_q - LC_W'(1);
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        act_en    = 1'b0;
        act_last  = 1'b0;
        unique case (state_q)
            WR_IDLE: req_ready = 1'b1;
            WR_BUSY: begin
                act_en   = 1'b1;
                act_last = (lat_q == '0);
            end
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/sbl_conflict_chk.sv
module sbl_conflict_chk #(
    parameter int unsigned ROW_W   = 4,
    parameter int unsigned WORD_W  = 2,
    parameter int unsigned DIST    = 4,
    parameter bit          PAIR_UP = 1'b1
) (
    input  logic                 w_valid,
    input  logic [ROW_W-1:0]     w_row,
    input  logic [WORD_W-1:0]    w_word,
    input  logic [ROW_W-1:0]     r_row,
    input  logic [WORD_W-1:0]    r_word,
    output sbl_pkg::cf_cause_e   cause
);
    import sbl_pkg::*;

    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(DIST - 1);

    logic [WORD_W-1:0] partner;

    generate
        if (PAIR_UP) begin : g_pair_up
            // line joins columns 2j and 2j+1
            assign partner = w_word ^ WORD_W'(1);
        end else begin : g_pair_down
            // line joins columns 2j-1 and 2j, wrapping across groups
            always_comb begin
                if (w_word[0])
                    partner = (w_word == LAST_WORD) ? '0 : w_word + WORD_W'(1);
                else
                    partner = (w_word == '0) ? LAST_WORD : w_word - WORD_W'(1);
            end
        end
    endgenerate

    // lowest-numbered cause wins
    always_comb begin
        cause = CF_NONE;
        if (w_valid) begin
            if (r_row == w_row)        cause = CF_ROW;
            else if (r_word == w_word) cause = CF_COL;
            else if (r_word == partner) cause = CF_LINE;
        end
    end

endmodule

// File: rtl/sbl_sat_cnt.sv
module sbl_sat_cnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && count != {W{1'b1}})
            count <= count + W'(1);
    end
endmodule

// File: rtl/sbl_rd_pipe.sv
module sbl_rd_pipe #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [DATA_W-1:0] din,
    output logic              dval,
    output logic [DATA_W-1:0] dout
);
    logic              v_q [RD_LAT];
    logic [DATA_W-1:0] d_q [RD_LAT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < RD_LAT; s++) begin
                v_q[s] <= 1'b0;
                d_q[s] <= '0;
            end
        end else begin
            v_q[0] <= issue;
            d_q[0] <= din;
            for (int s = 1; s < RD_LAT; s++) begin
                v_q[s] <= v_q[s-1];
                d_q[s] <= d_q[s-1];
            end
        end
    end

    assign dval = v_q[RD_LAT-1];
    assign dout = d_q[RD_LAT-1];
endmodule

// File: rtl/sbl_port_arbiter.sv
module sbl_port_arbiter #(
    parameter int unsigned ROWS    = 16,
    parameter int unsigned DIST    = 4,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned WR_LAT  = 5,
    parameter int unsigned RD_LAT  = 2,
    parameter bit          PAIR_UP = 1'b1,
    parameter int unsigned CNT_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    output logic                     wr_ready,
    input  logic [$clog2(ROWS)-1:0]  wr_row,
    input  logic [$clog2(DIST)-1:0]  wr_word,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_valid,
    output logic                     rd_ready,
    input  logic [$clog2(ROWS)-1:0]  rd_row,
    input  logic [$clog2(DIST)-1:0]  rd_word,
    output logic                     rd_dval,
    output logic [DATA_W-1:0]        rd_dout,
    output logic                     arr_wr_en,
    output logic                     arr_wr_last,
    output logic [$clog2(ROWS)-1:0]  arr_wr_row,
    output logic [$clog2(DIST)-1:0]  arr_wr_word,
    output logic [DATA_W-1:0]        arr_wr_data,
    output logic                     arr_rd_en,
    output logic [$clog2(ROWS)-1:0]  arr_rd_row,
    output logic [$clog2(DIST)-1:0]  arr_rd_word,
    input  logic [DATA_W-1:0]        arr_rd_data,
    output logic [CNT_W-1:0]         cnt_row,
    output logic [CNT_W-1:0]         cnt_col,
    output logic [CNT_W-1:0]         cnt_line
);
    import sbl_pkg::*;

    localparam int unsigned ROW_W  = $clog2(ROWS);
    localparam int unsigned WORD_W = $clog2(DIST);

    // write port state machine
    sbl_write_fsm #(
        .ROW_W (ROW_W),
        .WORD_W(WORD_W),
        .DATA_W(DATA_W),
        .WR_LAT(WR_LAT)
    ) u_wfsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(wr_valid),
        .req_row  (wr_row),
        .req_word (wr_word),
        .req_data (wr_data),
        .req_ready(wr_ready),
        .act_en   (arr_wr_en),
        .act_last (arr_wr_last),
        .act_row  (arr_wr_row),
        .act_word (arr_wr_word),
        .act_data (arr_wr_data)
    );

    // compare against the running write, or the one accepted this cycle
    logic              cmp_valid;
    logic [ROW_W-1:0]  cmp_row;
    logic [WORD_W-1:0] cmp_word;
    cf_cause_e         cause;

    assign cmp_valid = arr_wr_en | wr_valid;
    assign cmp_row   = arr_wr_en ? arr_wr_row  : wr_row;
    assign cmp_word  = arr_wr_en ? arr_wr_word : wr_word;

    sbl_conflict_chk #(
        .ROW_W  (ROW_W),
        .WORD_W (WORD_W),
        .DIST   (DIST),
        .PAIR_UP(PAIR_UP)
    ) u_cchk (
        .w_valid(cmp_valid),
        .w_row  (cmp_row),
        .w_word (cmp_word),
        .r_row  (rd_row),
        .r_word (rd_word),
        .cause  (cause)
    );

    assign rd_ready    = (cause == CF_NONE);
    assign arr_rd_en   = rd_valid && rd_ready;
    assign arr_rd_row  = rd_row;
    assign arr_rd_word = rd_word;

    sbl_rd_pipe #(
        .DATA_W(DATA_W),
        .RD_LAT(RD_LAT)
    ) u_rpipe (
        .clk  (clk),
        .rst_n(rst_n),
        .issue(arr_rd_en),
        .din  (arr_rd_data),
        .dval (rd_dval),
        .dout (rd_dout)
    );

    // one stall counter per cause
    logic [CNT_W-1:0] cnt_q [N_CAUSES];

    generate
        for (genvar k = 0; k < N_CAUSES; k++) begin : g_cnt
            sbl_sat_cnt #(.W(CNT_W)) u_cnt (
                .clk  (clk),
                .rst_n(rst_n),
                .inc  (rd_valid && (cause == cf_cause_e'(k + 1))),
                .count(cnt_q[k])
            );
        end
    endgenerate

    assign cnt_row  = cnt_q[0];
    assign cnt_col  = cnt_q[1];
    assign cnt_line = cnt_q[2];

endmodule

// File: rtl/sbl_port_arbiter_chk.sv
module sbl_port_arbiter_chk #(
    parameter int unsigned ROWS    = 16,
    parameter int unsigned DIST    = 4,
    parameter int unsigned DATA_W  = 8,
    parameter bit          PAIR_UP = 1'b1,
    parameter int unsigned CNT_W   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_ready,
    input logic                    rd_valid,
    input logic                    arr_wr_en,
    input logic                    arr_wr_last,
    input logic [$clog2(ROWS)-1:0] arr_wr_row,
    input logic [$clog2(DIST)-1:0] arr_wr_word,
    input logic [DATA_W-1:0]       arr_wr_data,
    input logic                    arr_rd_en,
    input logic [$clog2(ROWS)-1:0] arr_rd_row,
    input logic [$clog2(DIST)-1:0] arr_rd_word,
    input logic [CNT_W-1:0]        cnt_row,
    input logic [CNT_W-1:0]        cnt_col,
    input logic [CNT_W-1:0]        cnt_line
);
    // partner word derived from physical column positions
    function automatic int unsigned line_mate(input int unsigned w);
        int unsigned col;
        int unsigned mate;
        col = w + DIST;
        if (PAIR_UP) mate = (col % 2 == 0) ? col + 1 : col - 1;
        else         mate = (col % 2 == 1) ? col + 1 : col - 1;
        return mate % DIST;
    endfunction

    p_no_row_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en && arr_wr_en) |-> (arr_rd_row != arr_wr_row));

    p_no_col_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en && arr_wr_en) |-> (arr_rd_word != arr_wr_word));

    p_no_line_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en && arr_wr_en) |-> (int'(arr_rd_word) != line_mate(arr_wr_word)));

    p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> !wr_ready);

    p_write_retires_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_last |=> !arr_wr_en);

    p_write_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && !arr_wr_last) |=> (arr_wr_en && $stable(arr_wr_row)
            && $stable(arr_wr_word) && $stable(arr_wr_data)));

    p_cnt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> ($stable(cnt_row) && $stable(cnt_col) && $stable(cnt_line)));

    p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_row == {CNT_W{1'b1}}) |=> (cnt_row == {CNT_W{1'b1}}));

endmodule

bind sbl_port_arbiter sbl_port_arbiter_chk #(
    .ROWS   (ROWS),
    .DIST   (DIST),
    .DATA_W (DATA_W),
    .PAIR_UP(PAIR_UP),
    .CNT_W  (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .arr_wr_en  (arr_wr_en),
    .arr_wr_last(arr_wr_last),
    .arr_wr_row (arr_wr_row),
    .arr_wr_word(arr_wr_word),
    .arr_wr_data(arr_wr_data),
    .arr_rd_en  (arr_rd_en),
    .arr_rd_row (arr_rd_row),
    .arr_rd_word(arr_rd_word),
    .cnt_row    (cnt_row),
    .cnt_col    (cnt_col),
    .cnt_line   (cnt_line)
);

// File: tb/sbl_port_arbiter_tb.sv
module sbl_port_arbiter_tb_top;

    localparam int ROWS    = 16;
    localparam int DIST    = 4;
    localparam int DATA_W  = 8;
    localparam int WR_LAT  = 5;
    localparam int RD_LAT  = 2;
    localparam bit PAIR_UP = 1'b1;
    localparam int ROW_W   = $clog2(ROWS);
    localparam int WORD_W  = $clog2(DIST);
    localparam int CMAX    = 65535;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              wr_valid = 1'b0, rd_valid = 1'b0;
    logic [ROW_W-1:0]  wr_row = '0, rd_row = '0;
    logic [WORD_W-1:0] wr_word = '0, rd_word = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_ready, rd_ready, rd_dval;
    logic [DATA_W-1:0] rd_dout;
    logic              arr_wr_en, arr_wr_last, arr_rd_en;
    logic [ROW_W-1:0]  arr_wr_row, arr_rd_row;
    logic [WORD_W-1:0] arr_wr_word, arr_rd_word;
    logic [DATA_W-1:0] arr_wr_data, arr_rd_data;
    logic [15:0]       cnt_row, cnt_col, cnt_line;

    sbl_port_arbiter #(
        .ROWS(ROWS), .DIST(DIST), .DATA_W(DATA_W), .WR_LAT(WR_LAT),
        .RD_LAT(RD_LAT), .PAIR_UP(PAIR_UP), .CNT_W(16)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_row(wr_row),
        .wr_word(wr_word), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_row(rd_row),
        .rd_word(rd_word), .rd_dval(rd_dval), .rd_dout(rd_dout),
        .arr_wr_en(arr_wr_en), .arr_wr_last(arr_wr_last),
        .arr_wr_row(arr_wr_row), .arr_wr_word(arr_wr_word),
        .arr_wr_data(arr_wr_data), .arr_rd_en(arr_rd_en),
        .arr_rd_row(arr_rd_row), .arr_rd_word(arr_rd_word),
        .arr_rd_data(arr_rd_data),
        .cnt_row(cnt_row), .cnt_col(cnt_col), .cnt_line(cnt_line)
    );

    // behavioural storage array driven by the block's array-side pins
    logic [DATA_W-1:0] arr_mem [ROWS][DIST];
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++)
                for (int w = 0; w < DIST; w++)
                    arr_mem[r][w] <= '0;
        end else if (arr_wr_last) begin
            arr_mem[arr_wr_row][arr_wr_word] <= arr_wr_data;
        end
    end
    assign arr_rd_data = arr_mem[arr_rd_row][arr_rd_word];

    // reference model state
    int    total = 0, bad = 0;
    string tag = "R1";
    int    m_busy = 0, m_wrow = 0, m_wword = 0, m_wdata = 0;
    int    m_cnt [3] = '{0, 0, 0};
    int    ref_mem [ROWS][DIST];
    bit    pv [RD_LAT];
    int    pd [RD_LAT];
    bit    m_wacc, m_racc;
    bit    finished = 1'b0;

    function automatic int mate(input int w);
        int col;
        int mc;
        col = w + DIST;
        if (PAIR_UP) mc = (col % 2 == 0) ? col + 1 : col - 1;
        else         mc = (col % 2 == 1) ? col + 1 : col - 1;
        return mc % DIST;
    endfunction

    task automatic chk(input string name, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit wv, input int wr, input int ww, input int wd,
                       input bit rv, input int rr, input int rw);
        bit act;
        int arow, aword, cause, rdat;
        @(negedge clk);
        wr_valid = wv; wr_row = ROW_W'(wr); wr_word = WORD_W'(ww); wr_data = DATA_W'(wd);
        rd_valid = rv; rd_row = ROW_W'(rr); rd_word = WORD_W'(rw);
        #2;
        act = 1'b0; arow = 0; aword = 0;
        if (m_busy > 0) begin act = 1'b1; arow = m_wrow; aword = m_wword; end
        else if (wv)    begin act = 1'b1; arow = wr;     aword = ww;      end
        cause = 0;
        if (act) begin
            if (rr == arow)            cause = 1;
            else if (rw == aword)      cause = 2;
            else if (rw == mate(aword)) cause = 3;
        end
        chk("wr_ready", int'(wr_ready), int'(m_busy == 0));
        chk("rd_ready", int'(rd_ready), int'(cause == 0));
        chk("arr_wr_en", int'(arr_wr_en), int'(m_busy > 0));
        chk("arr_wr_last", int'(arr_wr_last), int'(m_busy == 1));
        if (m_busy > 0) begin
            chk("arr_wr_row", int'(arr_wr_row), m_wrow);
            chk("arr_wr_word", int'(arr_wr_word), m_wword);
            chk("arr_wr_data", int'(arr_wr_data), m_wdata);
        end
        chk("rd_dval", int'(rd_dval), int'(pv[RD_LAT-1]));
        if (pv[RD_LAT-1]) chk("rd_dout", int'(rd_dout), pd[RD_LAT-1]);
        chk("cnt_row", int'(cnt_row), m_cnt[0]);
        chk("cnt_col", int'(cnt_col), m_cnt[1]);
        chk("cnt_line", int'(cnt_line), m_cnt[2]);
        @(posedge clk);
        m_wacc = wv && (m_busy == 0);
        m_racc = rv && (cause == 0);
        rdat = ref_mem[rr][rw];
        for (int s = RD_LAT - 1; s > 0; s--) begin pv[s] = pv[s-1]; pd[s] = pd[s-1]; end
        pv[0] = m_racc; pd[0] = rdat;
        if (rv && cause != 0 && m_cnt[cause-1] < CMAX) m_cnt[cause-1]++;
        if (m_busy == 1) ref_mem[m_wrow][m_wword] = m_wdata;
        if (m_busy > 0) m_busy--;
        else if (wv) begin m_busy = WR_LAT; m_wrow = wr; m_wword = ww; m_wdata = wd; end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    // hold each request until the model says it was accepted
    task automatic xfer(input bit wv, input int wr, input int ww, input int wd,
                        input bit rv, input int rr, input int rw);
        bit wp, rp;
        wp = wv; rp = rv;
        for (int n = 0; n < 100 && (wp || rp); n++) begin
            cyc(wp, wr, ww, wd, rp, rr, rw);
            if (m_wacc) wp = 1'b0;
            if (m_racc) rp = 1'b0;
        end
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int w = 0; w < DIST; w++) ref_mem[r][w] = 0;
        for (int s = 0; s < RD_LAT; s++) begin pv[s] = 1'b0; pd[s] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        tag = "R1"; idle(2);
        tag = "R2"; xfer(1, 3, 1, 8'hA5, 0, 0, 0); idle(WR_LAT + 2);
        tag = "R3"; xfer(0, 0, 0, 0, 1, 3, 1); idle(RD_LAT + 1);
        tag = "R3"; xfer(1, 2, 0, 8'h11, 1, 5, 2); idle(WR_LAT + 2);
        tag = "R4"; xfer(1, 4, 0, 8'h22, 0, 0, 0); xfer(0, 0, 0, 0, 1, 4, 3); idle(4);
        tag = "R5"; xfer(1, 6, 2, 8'h33, 0, 0, 0); xfer(0, 0, 0, 0, 1, 9, 2); idle(4);
        tag = "R6"; xfer(1, 7, 2, 8'h44, 0, 0, 0); xfer(0, 0, 0, 0, 1, 10, 3); idle(4);
        tag = "R6"; xfer(1, 7, 1, 8'h45, 0, 0, 0); xfer(0, 0, 0, 0, 1, 11, 0); idle(4);
        tag = "R7"; xfer(1, 8, 1, 8'h3C, 0, 0, 0); xfer(0, 0, 0, 0, 1, 8, 1); idle(RD_LAT + 2);
        tag = "R8"; xfer(1, 12, 3, 8'h5A, 1, 12, 0); idle(RD_LAT + 2);
        tag = "R8"; xfer(1, 13, 0, 8'h6B, 1, 14, 1); idle(WR_LAT + 2);

        tag = "R9";
        for (int i = 0; i < 600; i++)
            cyc(bit'($urandom % 2), int'($urandom % ROWS), int'($urandom % DIST), int'($urandom % 256),
                bit'($urandom % 2), int'($urandom % ROWS), int'($urandom % DIST));
        idle(WR_LAT + RD_LAT + 2);

        tag = "R9";
        for (int i = 0; i < CMAX + 20; i++) cyc(1, 1, 0, i % 256, 1, 1, 2);
        idle(WR_LAT + 2);
        chk("cnt_row_saturated", int'(cnt_row), CMAX);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog %s: actual=running expected=finished", tag);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule